// File: doc/BRIEF.md
# Banked Data Address Unit

This unit turns short instruction operands into full data-memory addresses for a small 8-bit processor core. The data space is 4096 bytes, split into sixteen pages of 256 bytes. A 4-bit page register supplies the upper address bits for ordinary page-relative accesses. An instruction-level "set page" operation writes a literal into that register.

When the operand's window flag is set, the page register plays no part. The 8-bit operand then selects one byte of a fixed 256-byte window. The lower half of the window is the start of page 0. The upper half is the top of page 15, where control registers sit. As a result, both scratch variables and control registers can be reached without first changing the page.

A second path copies one byte between any two full 12-bit addresses. It reads the source in one cycle and writes the destination in the next. It never consults or changes the page register, so it can cross pages freely. A 4096x8 synchronous RAM model is included, so that reads, writes and copies can be observed at the ports.

Top module: `bank_addr_unit`

## Requirements
- R1: While reset is active and after it is released, `page_q` is 0, and `mv_busy` and `mv_done` are 0.
- R2: A cycle with `page_ld` high loads `page_lit` into `page_q`; the new value is visible after that clock edge.
- R3: With `win_sel` low, `phys_addr` equals {`page_q`, `opnd`}, with the page in bits 11:8 and the operand in bits 7:0.
- R4: With `win_sel` high and `opnd` in 0x00..0x7F, `phys_addr` is 0x000 + `opnd`, whatever the value of `page_q`.
- R5: With `win_sel` high and `opnd` in 0x80..0xFF, `phys_addr` is 0xF00 + `opnd` (for example, 0x89 gives 0xF89), whatever the value of `page_q`.
- R6: An access with `acc_req` and `acc_we` high writes `wdata` at `phys_addr` on that clock edge. An access with `acc_req` high and `acc_we` low returns the byte at `phys_addr` on `rd_data` one cycle later.
- R7: When `page_ld` and a page-relative access fall in the same cycle, the access uses the page value from before the load.
- R8: A `mv_start` pulse while idle copies the byte at `mv_src` to `mv_dst`. `mv_busy` is high for the two cycles after the start edge. `mv_done` is high for exactly the one cycle after that, while `mv_busy` is low.
- R9: A copy leaves `page_q` unchanged.
- R10: While `mv_busy` is high, `acc_req` and `mv_start` are ignored: no write lands and no second copy is started.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| page_ld | input | 1 | Load the page register this cycle |
| page_lit | input | 4 | Literal for the page register |
| acc_req | input | 1 | Operand access request |
| acc_we | input | 1 | Access is a write |
| win_sel | input | 1 | Operand addresses the fixed window |
| opnd | input | 8 | Instruction operand (low address bits) |
| wdata | input | 8 | Write data |
| rd_data | output | 8 | Read data, one cycle after a read |
| phys_addr | output | 12 | Resolved physical address of the operand |
| page_q | output | 4 | Current page register |
| mv_start | input | 1 | Start a memory-to-memory copy |
| mv_src | input | 12 | Copy source address |
| mv_dst | input | 12 | Copy destination address |
| mv_busy | output | 1 | Copy in progress |
| mv_done | output | 1 | One-cycle completion pulse |

## Verification
The bench probes the window seam at operands 0x7F and 0x80. A design that decoded the wrong bit there would send scratch writes into the control-register region, or the reverse. It checks that the window ignores a nonzero page, since a design that OR'd the page into the address would alias window bytes across pages. A same-cycle page load with an access would reveal a design that forwards the new page and so writes into the wrong page. Copies are run across pages and while accesses and extra start pulses are pushed into the busy window. A design that let those through would corrupt a stored byte, restart the copy, or disturb the page register.

// File: rtl/bau_pkg.sv
package bau_pkg;
  localparam int ADDR_W = 12;
  localparam int OFF_W  = 8;
  localparam int DATA_W = 8;
  localparam int PAGE_W = ADDR_W - OFF_W;
  localparam int DEPTH  = 1 << ADDR_W;

  typedef logic [ADDR_W-1:0] addr_t;
  typedef logic [OFF_W-1:0]  off_t;
  typedef logic [PAGE_W-1:0] page_t;
  typedef logic [DATA_W-1:0] data_t;

  typedef enum logic [1:0] {MV_IDLE, MV_READ, MV_WRITE} mv_state_e;

  // Window: operand MSB picks the bottom of the lowest page or the top of the highest.
  function automatic addr_t window_map(input off_t o);
    return {{PAGE_W{o[OFF_W-1]}}, o};
  endfunction
endpackage

// File: rtl/page_reg.sv
module page_reg
  import bau_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  ld,
  input  page_t lit,
  output page_t q
);
  page_t q_nxt;

  always_comb begin
    q_nxt = q;
    if (ld) q_nxt = lit;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end
endmodule

// File: rtl/addr_resolve.sv
module addr_resolve
  import bau_pkg::*;
(
  input  logic  win_sel,
  input  page_t page,
  input  off_t  opnd,
  output addr_t phys
);
  always_comb begin
    if (win_sel) phys = window_map(opnd);
    else         phys = {page, opnd};
  end
endmodule

// File: rtl/move_seq.sv
module move_seq
  import bau_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  start,
  input  addr_t src,
  input  addr_t dst,
  input  data_t ram_rdata,
  output logic  busy,
  output logic  done,
  output logic  ram_en,
  output logic  ram_we,
  output addr_t ram_addr,
  output data_t ram_wdata
);
  mv_state_e st, st_nxt;
  addr_t     src_q, dst_q, src_nxt, dst_nxt;
  logic      done_nxt;

  always_comb begin
    st_nxt   = st;
    src_nxt  = src_q;
    dst_nxt  = dst_q;
    done_nxt = 1'b0;
    unique case (st)
      MV_IDLE: if (start) begin
        st_nxt  = MV_READ;
        src_nxt = src;
        dst_nxt = dst;
      end
      MV_READ:  st_nxt = MV_WRITE;
      MV_WRITE: begin
        st_nxt   = MV_IDLE;
        done_nxt = 1'b1;
      end
      default:  st_nxt = MV_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= MV_IDLE;
      src_q <= '0;
      dst_q <= '0;
      done  <= 1'b0;
    end else begin
      st    <= st_nxt;
      src_q <= src_nxt;
      dst_q <= dst_nxt;
      done  <= done_nxt;
    end
  end

  assign busy      = (st != MV_IDLE);
  assign ram_en    = busy;
  assign ram_we    = (st == MV_WRITE);
  assign ram_addr  = (st == MV_WRITE) ? dst_q : src_q;
  assign ram_wdata = ram_rdata;
endmodule

// File: rtl/data_ram.sv
module data_ram
  import bau_pkg::*;
(
  input  logic  clk,
  input  logic  en,
  input  logic  we,
  input  addr_t addr,
  input  data_t wdata,
  output data_t rdata
);
  data_t mem [DEPTH];

  always_ff @(posedge clk) begin
    if (en) begin
      if (we) mem[addr] <= wdata;
      else    rdata     <= mem[addr];
    end
  end
endmodule

// File: rtl/bank_addr_unit.sv
module bank_addr_unit
  import bau_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 page_ld,
  input  logic [PAGE_W-1:0]    page_lit,
  input  logic                 acc_req,
  input  logic                 acc_we,
  input  logic                 win_sel,
  input  logic [OFF_W-1:0]     opnd,
  input  logic [DATA_W-1:0]    wdata,
  output logic [DATA_W-1:0]    rd_data,
  output logic [ADDR_W-1:0]    phys_addr,
  output logic [PAGE_W-1:0]    page_q,
  input  logic                 mv_start,
  input  logic [ADDR_W-1:0]    mv_src,
  input  logic [ADDR_W-1:0]    mv_dst,
  output logic                 mv_busy,
  output logic                 mv_done
);
  logic [1:0] rst_sync;
  logic       rst_q_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= '0;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_q_n = rst_sync[1];

  page_reg u_page (
    .clk(clk), .rst_n(rst_q_n), .ld(page_ld), .lit(page_lit), .q(page_q)
  );

  addr_resolve u_res (
    .win_sel(win_sel), .page(page_q), .opnd(opnd), .phys(phys_addr)
  );

  logic  mv_en, mv_we;
  addr_t mv_addr;
  data_t mv_wdata, ram_rdata;

  move_seq u_mv (
    .clk(clk), .rst_n(rst_q_n), .start(mv_start), .src(mv_src), .dst(mv_dst),
    .ram_rdata(ram_rdata), .busy(mv_busy), .done(mv_done),
    .ram_en(mv_en), .ram_we(mv_we), .ram_addr(mv_addr), .ram_wdata(mv_wdata)
  );

  logic  ram_en, ram_we;
  addr_t ram_addr;
  data_t ram_wdata;

  // Copy sequencer owns the RAM port while busy; operand accesses are dropped.
  always_comb begin
    if (mv_busy) begin
      ram_en    = mv_en;
      ram_we    = mv_we;
      ram_addr  = mv_addr;
      ram_wdata = mv_wdata;
    end else begin
      ram_en    = acc_req;
      ram_we    = acc_we;
      ram_addr  = phys_addr;
      ram_wdata = wdata;
    end
  end

  data_ram u_ram (
    .clk(clk), .en(ram_en), .we(ram_we), .addr(ram_addr),
    .wdata(ram_wdata), .rdata(ram_rdata)
  );

  assign rd_data = ram_rdata;
endmodule

// File: rtl/bank_addr_chk.sv
module bank_addr_chk
  import bau_pkg::*;
(
  input logic              clk,
  input logic              rst_q_n,
  input logic              page_ld,
  input logic [PAGE_W-1:0] page_lit,
  input logic              win_sel,
  input logic [OFF_W-1:0]  opnd,
  input logic [ADDR_W-1:0] phys_addr,
  input logic [PAGE_W-1:0] page_q,
  input logic              mv_start,
  input logic              mv_busy,
  input logic              mv_done
);
  assert_reset_R1: assert property (@(posedge clk)
    !rst_q_n |-> (page_q == '0 && !mv_busy && !mv_done));

  assert_page_load_R2: assert property (@(posedge clk) disable iff (!rst_q_n)
    page_ld |=> page_q == $past(page_lit));

  assert_page_hold_R9: assert property (@(posedge clk) disable iff (!rst_q_n)
    !page_ld |=> $stable(page_q));

  assert_paged_R3: assert property (@(posedge clk) disable iff (!rst_q_n)
    !win_sel |-> (phys_addr[ADDR_W-1:OFF_W] == page_q && phys_addr[OFF_W-1:0] == opnd));

  assert_win_low_R4: assert property (@(posedge clk) disable iff (!rst_q_n)
    (win_sel && !opnd[OFF_W-1]) |-> phys_addr[ADDR_W-1:OFF_W] == '0);

  assert_win_high_R5: assert property (@(posedge clk) disable iff (!rst_q_n)
    (win_sel && opnd[OFF_W-1]) |-> phys_addr[ADDR_W-1:OFF_W] == '1);

  assert_mv_accept_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mv_start && !mv_busy) |=> mv_busy);

  assert_mv_pulse_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    mv_done |=> !mv_done);

  assert_mv_excl_R8: assert property (@(posedge clk) disable iff (!rst_q_n)
    mv_done |-> !mv_busy);

  assert_mv_ends_R10: assert property (@(posedge clk) disable iff (!rst_q_n)
    (mv_busy && $past(mv_busy)) |=> !mv_busy);
endmodule

bind bank_addr_unit bank_addr_chk u_chk (
  .clk(clk), .rst_q_n(rst_q_n), .page_ld(page_ld), .page_lit(page_lit),
  .win_sel(win_sel), .opnd(opnd), .phys_addr(phys_addr), .page_q(page_q),
  .mv_start(mv_start), .mv_busy(mv_busy), .mv_done(mv_done)
);

// File: tb/tb_bank_addr_unit.sv
module tb_bank_addr_unit;
  logic        clk = 1'b0;
  logic        rst_n;
  logic        page_ld, acc_req, acc_we, win_sel, mv_start;
  logic [3:0]  page_lit;
  logic [7:0]  opnd, wdata, rd_data;
  logic [11:0] phys_addr, mv_src, mv_dst;
  logic [3:0]  page_q;
  logic        mv_busy, mv_done;

  int checks = 0, errors = 0;
  bit finished = 0;
  logic [7:0] mdl [int];
  logic [7:0] exp_q [$];
  string      tag_q [$];

  always #10 clk = ~clk;

  bank_addr_unit dut (.*);

  task automatic chk(string r, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", r, act, exp);
    end
  endtask

  // Monitor: pops one expected read result per negedge after a read edge.
  always @(negedge clk) begin
    if (exp_q.size() > 0) chk(tag_q.pop_front(), rd_data, exp_q.pop_front());
  end

  task automatic idle_in();
    page_ld = 0; acc_req = 0; acc_we = 0; win_sel = 0; mv_start = 0;
    page_lit = 0; opnd = 0; wdata = 0; mv_src = 0; mv_dst = 0;
  endtask

  task automatic set_page(logic [3:0] p);
    @(negedge clk); page_ld = 1; page_lit = p;
    @(posedge clk); #1 page_ld = 0;
  endtask

  task automatic access(string r, bit we, bit win, logic [7:0] o,
                        logic [7:0] d, logic [11:0] exp_addr);
    @(negedge clk);
    acc_req = 1; acc_we = we; win_sel = win; opnd = o; wdata = d;
    #1 chk(r, phys_addr, exp_addr);
    @(posedge clk); #1;
    if (we) mdl[exp_addr] = d;
    else begin exp_q.push_back(mdl[exp_addr]); tag_q.push_back(r); end
    acc_req = 0; acc_we = 0;
  endtask

  task automatic put(logic [11:0] a, logic [7:0] d);
    set_page(a[11:8]);
    access("R6", 1, 0, a[7:0], d, a);
  endtask

  task automatic get(string r, logic [11:0] a);
    set_page(a[11:8]);
    access(r, 0, 0, a[7:0], 8'h00, a);
  endtask

  task automatic copy(logic [11:0] s, logic [11:0] d, bit intrude,
                      logic [11:0] xdst);
    @(negedge clk); mv_start = 1; mv_src = s; mv_dst = d;
    @(posedge clk); #1 mv_start = 0;
    if (intrude) begin
      acc_req = 1; acc_we = 1; win_sel = 0; opnd = 8'h50; wdata = 8'hEE;
      mv_start = 1; mv_src = d; mv_dst = xdst;
    end
    @(negedge clk); chk("R8 busy c1", mv_busy, 1); chk("R8 done c1", mv_done, 0);
    @(posedge clk); #1 begin acc_req = 0; acc_we = 0; mv_start = 0; end
    @(negedge clk); chk("R8 busy c2", mv_busy, 1);
    @(negedge clk); chk("R8 busy end", mv_busy, 0); chk("R8 done", mv_done, 1);
    mdl[d] = mdl[s];
    @(negedge clk); chk("R8 done pulse", mv_done, 0);
    chk("R10 no restart", mv_busy, 0);
  endtask

  initial begin
    #4ms;
    if (!finished) begin
      errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    idle_in();
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk("R1 page in reset", page_q, 0);
    chk("R1 busy in reset", mv_busy, 0);
    rst_n = 1;
    repeat (4) @(negedge clk);
    chk("R1 page", page_q, 0);
    chk("R1 busy", mv_busy, 0);
    chk("R1 done", mv_done, 0);

    access("R3 page0", 1, 0, 8'h22, 8'hA1, 12'h022);
    set_page(4'h5);
    @(negedge clk); chk("R2 load", page_q, 4'h5);
    access("R3 page5 wr", 1, 0, 8'h22, 8'h5B, 12'h522);
    access("R6 read page5", 0, 0, 8'h22, 8'h00, 12'h522);
    access("R4 window low wr", 1, 1, 8'h22, 8'h3C, 12'h022);
    access("R6 page5 unchanged", 0, 0, 8'h22, 8'h00, 12'h522);
    access("R4 window low rd", 0, 1, 8'h22, 8'h00, 12'h022);
    access("R5 window 0x89", 1, 1, 8'h89, 8'h77, 12'hF89);
    access("R4 seam 0x7F", 1, 1, 8'h7F, 8'h12, 12'h07F);
    access("R5 seam 0x80", 1, 1, 8'h80, 8'h34, 12'hF80);
    get("R5 read F89 paged", 12'hF89);
    get("R4 read 07F paged", 12'h07F);
    get("R5 read F80 paged", 12'hF80);

    // R7: same-cycle page load and paged write uses old page
    put(12'h240, 8'h11);
    set_page(4'hF);
    @(negedge clk);
    page_ld = 1; page_lit = 4'h2;
    acc_req = 1; acc_we = 1; win_sel = 0; opnd = 8'h40; wdata = 8'h99;
    #1 chk("R7 old page addr", phys_addr, 12'hF40);
    @(posedge clk); #1 begin page_ld = 0; acc_req = 0; acc_we = 0; end
    mdl[12'hF40] = 8'h99;
    @(negedge clk); chk("R7 new page", page_q, 4'h2);
    access("R7 240 untouched", 0, 0, 8'h40, 8'h00, 12'h240);
    get("R7 F40 written", 12'hF40);

    // R8/R9: cross-page copies
    put(12'h3A5, 8'hC7);
    set_page(4'h6);
    copy(12'h3A5, 12'hC10, 0, 12'h000);
    chk("R9 page kept", page_q, 4'h6);
    get("R8 copy dst C10", 12'hC10);
    copy(12'hF80, 12'h07E, 0, 12'h000);
    get("R8 copy dst 07E", 12'h07E);

    // R10: accesses and restart during busy are ignored
    put(12'h650, 8'h44);
    put(12'h651, 8'h45);
    set_page(4'h6);
    copy(12'h3A5, 12'h700, 1, 12'h651);
    chk("R9 page kept 2", page_q, 4'h6);
    get("R10 650 kept", 12'h650);
    get("R10 651 kept", 12'h651);
    get("R8 copy dst 700", 12'h700);

    repeat (3) @(negedge clk);
    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule